// File: doc/BRIEF.md
# Single-Precision Float and Integer Conversion Unit

This block converts between IEEE-754 single-precision values and 32-bit two's-complement integers. One unit serves six operations, each picked by a pair of a 4-bit primary opcode and a 4-bit sub-opcode. Four of them turn a float into an integer with a rounding direction fixed by the opcode. A fifth does the same with the rounding direction taken from the `rnd_mode` input. The sixth turns a signed integer into a float, and it also rounds with `rnd_mode`. The result is the raw 32-bit pattern meant for a data register. Two flags come with each result: invalid, for NaN or out-of-range inputs, and inexact, for lost precision. Subnormal float inputs are used at their true value and are not flushed to zero.

Requests enter through a valid/ready handshake. `in_ready` is high only when no operation is in flight. A request is taken on a clock edge where `in_valid` and `in_ready` are both high. The opcode pair, the operand and `rnd_mode` are all sampled on that edge. `in_ready` then drops for exactly one cycle. On the second edge after acceptance the result is registered and `out_valid` pulses for one cycle. Results cannot be stalled: `out_valid` is a done strobe, and the consumer must capture `out_result` and the flags while it is high.

Top module: `fcv_unit`

## Requirements
- R1: After reset, `out_valid` is 0, `in_ready` is 1, and `out_result`, `out_invalid` and `out_inexact` are all 0.
- R2: A request is accepted on an edge where `in_valid` and `in_ready` are both 1 and the opcode pair is recognized. In the cycle after acceptance, `in_ready` and `out_valid` are both 0. In the cycle after that, `out_valid` is 1 for exactly one cycle, and `in_ready` is 1 again.
- R3: Primary 0xC with sub 0x0 converts a float to an integer, rounding to nearest with ties going to the even integer.
- R4: Primary 0xD with sub 0x0 converts a float to an integer, truncating toward zero.
- R5: Primary 0xE with sub 0x0 rounds toward plus infinity. Primary 0xF with sub 0x0 rounds toward minus infinity.
- R6: Primary 0x4 with sub 0x1 converts a float to an integer using `rnd_mode` as sampled at acceptance. The encoding is 0 nearest-even, 1 toward zero, 2 toward plus infinity, 3 toward minus infinity.
- R7: For a float-to-integer conversion, any of the following raises `out_invalid` with `out_inexact` low: a NaN, an infinity, or a rounded value outside [-2^31, 2^31-1]. The result is 0x80000000 for a negative non-NaN input and 0x7FFFFFFF otherwise. An exact -2^31 is a valid result.
- R8: A float-to-integer conversion raises `out_inexact` exactly when nonzero fraction bits are discarded. Subnormal inputs give 0, +1 or -1 according to the rounding direction.
- R9: Primary 0x0 with sub 0x9 converts a signed 32-bit integer to single precision. It rounds with `rnd_mode`, raises `out_inexact` when significant bits are lost and never raises `out_invalid`. An input of 0 gives +0.
- R10: A request whose opcode pair is not one of the six above is taken and dropped. No `out_valid` follows, and `out_result` and the flags keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit idle, can take a request |
| in_opcode | input | 4 | Primary opcode |
| in_subop | input | 4 | Sub-opcode |
| in_operand | input | 32 | Float or integer operand |
| rnd_mode | input | 2 | Current rounding direction |
| out_valid | output | 1 | One-cycle done strobe |
| out_result | output | 32 | Converted bit pattern |
| out_invalid | output | 1 | Invalid operation flag |
| out_inexact | output | 1 | Precision lost flag |

## Verification
The float sweep covers every exponent from deep below one up past the 2^31 limit, plus the subnormal and all-ones exponents. It pairs each exponent with mantissas that produce exact halves, values just above and below a half, and exact integers. This catches ties resolved away from even, directed rounding applied to the magnitude instead of the signed value, and a sticky bit that is dropped once the shift reaches past the word. The exact -2^31 case and the neighbours on either side of it catch a saturation bound that is off by one.

The integer sweep probes values just around every power of two from 2^20 up to 2^31, and also the most negative integer. There a wrong carry out of rounding would leave the exponent one short, or would corrupt the sign path through the magnitude.

Changing `rnd_mode` right after acceptance exposes a unit that reads the mode late. An unrecognized opcode pair checks that stale outputs are not re-strobed.

// File: rtl/fcv_pkg.sv
package fcv_pkg;
  localparam int WORD_W = 32;
  localparam int EXP_W  = 8;
  localparam int FRAC_W = 23;
  localparam int MANT_W = FRAC_W + 1;
  localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
  localparam int OP_W   = 4;

  localparam logic [EXP_W-1:0]  EXP_ONES = '1;
  localparam logic [WORD_W-1:0] SAT_POS  = {1'b0, {(WORD_W-1){1'b1}}};
  localparam logic [WORD_W-1:0] SAT_NEG  = {1'b1, {(WORD_W-1){1'b0}}};

  // opcode pairs
  localparam logic [OP_W-1:0] OPC_NEAR  = 4'hC;
  localparam logic [OP_W-1:0] OPC_TRUNC = 4'hD;
  localparam logic [OP_W-1:0] OPC_CEIL  = 4'hE;
  localparam logic [OP_W-1:0] OPC_FLOOR = 4'hF;
  localparam logic [OP_W-1:0] OPC_DYN   = 4'h4;
  localparam logic [OP_W-1:0] OPC_ITOF  = 4'h0;
  localparam logic [OP_W-1:0] SUB_FIX   = 4'h0;
  localparam logic [OP_W-1:0] SUB_DYN   = 4'h1;
  localparam logic [OP_W-1:0] SUB_ITOF  = 4'h9;

  typedef enum logic [1:0] {
    RM_NEAREST = 2'd0,
    RM_ZERO    = 2'd1,
    RM_UP      = 2'd2,
    RM_DOWN    = 2'd3
  } rmode_e;

  typedef struct packed {
    logic   legal;
    logic   to_float;
    rmode_e rm;
  } dec_t;

  // Whether a truncated magnitude must be bumped by one unit.
  function automatic logic round_up(input rmode_e rm, input logic sign,
                                    input logic lsb, input logic half,
                                    input logic rest);
    logic r;
    case (rm)
      RM_NEAREST: r = half & (rest | lsb);
      RM_ZERO:    r = 1'b0;
      RM_UP:      r = ~sign & (half | rest);
      default:    r = sign & (half | rest);
    endcase
    return r;
  endfunction
endpackage

// File: rtl/fcv_decode.sv
module fcv_decode
  import fcv_pkg::*;
(
  input  logic [OP_W-1:0] opcode,
  input  logic [OP_W-1:0] subop,
  input  logic [1:0]      mode_in,
  output dec_t            dec
);
  always_comb begin
    dec.legal    = 1'b0;
    dec.to_float = 1'b0;
    dec.rm       = rmode_e'(mode_in);
    case (opcode)
      OPC_NEAR: begin
        dec.legal = (subop == SUB_FIX);
        dec.rm    = RM_NEAREST;
      end
      OPC_TRUNC: begin
        dec.legal = (subop == SUB_FIX);
        dec.rm    = RM_ZERO;
      end
      OPC_CEIL: begin
        dec.legal = (subop == SUB_FIX);
        dec.rm    = RM_UP;
      end
      OPC_FLOOR: begin
        dec.legal = (subop == SUB_FIX);
        dec.rm    = RM_DOWN;
      end
      OPC_DYN: dec.legal = (subop == SUB_DYN);
      OPC_ITOF: begin
        dec.legal    = (subop == SUB_ITOF);
        dec.to_float = 1'b1;
      end
      default: dec.legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/fcv_f2i.sv
module fcv_f2i
  import fcv_pkg::*;
(
  input  logic [WORD_W-1:0] op_a,
  input  rmode_e            rm,
  output logic [WORD_W-1:0] res,
  output logic              inv,
  output logic              inx
);
  localparam int EXT_W = MANT_W + WORD_W;
  localparam int SH_W  = EXP_W + 1;
  // exponent at which the mantissa LSB weighs exactly one
  localparam logic [SH_W-1:0] UNIT_EXP = SH_W'(BIAS + FRAC_W);
  // exponent at which magnitude reaches 2^(WORD_W-1)
  localparam logic [SH_W-1:0] OVF_EXP  = SH_W'(BIAS + WORD_W - 1);

  logic              sgn;
  logic [EXP_W-1:0]  ex;
  logic [FRAC_W-1:0] fr;
  logic [MANT_W-1:0] mant;
  logic [SH_W-1:0]   e_eff;
  logic [SH_W-1:0]   lsh;
  logic [SH_W-1:0]   rsh;
  logic [EXT_W-1:0]  ext;
  logic [MANT_W-1:0] ipart;
  logic              half;
  logic              rest;
  logic              inc;
  logic [WORD_W-1:0] mag;

  assign sgn   = op_a[WORD_W-1];
  assign ex    = op_a[WORD_W-2 -: EXP_W];
  assign fr    = op_a[FRAC_W-1:0];
  assign mant  = {|ex, fr};
  assign e_eff = (ex == '0) ? SH_W'(1) : {1'b0, ex};
  assign lsh   = e_eff - UNIT_EXP;
  assign rsh   = UNIT_EXP - e_eff;
  assign ext   = {mant, {WORD_W{1'b0}}} >> rsh;

  // integer part, half bit and sticky for right-shifted operands
  always_comb begin
    ipart = '0;
    half  = 1'b0;
    rest  = 1'b0;
    if (rsh > SH_W'(WORD_W)) begin
      rest = |mant;
    end else begin
      ipart = ext[EXT_W-1 -: MANT_W];
      half  = ext[WORD_W-1];
      rest  = |ext[WORD_W-2:0];
    end
  end

  assign inc = round_up(rm, sgn, ipart[0], half, rest);

  always_comb begin
    res = '0;
    inv = 1'b0;
    inx = 1'b0;
    mag = '0;
    if (ex == EXP_ONES) begin
      inv = 1'b1;
      res = (sgn && fr == '0) ? SAT_NEG : SAT_POS;
    end else if (e_eff >= OVF_EXP) begin
      if (sgn && e_eff == OVF_EXP && fr == '0) begin
        res = SAT_NEG;
      end else begin
        inv = 1'b1;
        res = sgn ? SAT_NEG : SAT_POS;
      end
    end else if (e_eff >= UNIT_EXP) begin
      mag = WORD_W'(mant) << lsh;
      res = sgn ? (~mag + 1'b1) : mag;
    end else begin
      mag = WORD_W'(ipart) + WORD_W'(inc);
      inx = half | rest;
      res = sgn ? (~mag + 1'b1) : mag;
    end
  end
endmodule

// File: rtl/fcv_i2f.sv
module fcv_i2f
  import fcv_pkg::*;
(
  input  logic [WORD_W-1:0] op_a,
  input  rmode_e            rm,
  output logic [WORD_W-1:0] res,
  output logic              inx
);
  localparam int GUARD = WORD_W - MANT_W;
  localparam int POS_W = $clog2(WORD_W);

  logic              sgn;
  logic [WORD_W-1:0] mag;
  logic [POS_W-1:0]  lead;
  logic [WORD_W-1:0] norm;
  logic [MANT_W-1:0] kept;
  logic              half;
  logic              rest;
  logic              inc;
  logic [MANT_W:0]   sum;
  logic [EXP_W-1:0]  exp_v;
  logic [FRAC_W-1:0] frac_v;

  assign sgn = op_a[WORD_W-1];
  assign mag = sgn ? (~op_a + 1'b1) : op_a;

  // position of the leading one; the highest set bit wins
  always_comb begin
    lead = '0;
    for (int i = 0; i < WORD_W; i++) begin
      if (mag[i]) lead = POS_W'(i);
    end
  end

  assign norm = mag << (POS_W'(WORD_W - 1) - lead);
  assign kept = norm[WORD_W-1 -: MANT_W];
  assign half = norm[GUARD-1];
  assign rest = |norm[GUARD-2:0];
  assign inc  = round_up(rm, sgn, kept[0], half, rest);
  assign sum  = {1'b0, kept} + (MANT_W+1)'(inc);

  assign exp_v  = EXP_W'(BIAS) + EXP_W'(lead) + EXP_W'(sum[MANT_W]);
  assign frac_v = sum[MANT_W] ? sum[MANT_W-1:1] : sum[FRAC_W-1:0];
  assign res    = (mag == '0) ? '0 : {sgn, exp_v, frac_v};
  assign inx    = half | rest;
endmodule

// File: rtl/fcv_unit.sv
module fcv_unit
  import fcv_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [OP_W-1:0]   in_opcode,
  input  logic [OP_W-1:0]   in_subop,
  input  logic [WORD_W-1:0] in_operand,
  input  logic [1:0]        rnd_mode,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_result,
  output logic              out_invalid,
  output logic              out_inexact
);
  dec_t              dec;
  logic              accept;
  logic              busy_q;
  logic [WORD_W-1:0] opnd_q;
  rmode_e            rm_q;
  logic              tof_q;
  logic [WORD_W-1:0] f2i_res;
  logic              f2i_inv;
  logic              f2i_inx;
  logic [WORD_W-1:0] i2f_res;
  logic              i2f_inx;

  fcv_decode u_dec (
    .opcode  (in_opcode),
    .subop   (in_subop),
    .mode_in (rnd_mode),
    .dec     (dec)
  );

  assign in_ready = ~busy_q;
  assign accept   = in_valid & in_ready & dec.legal;

  fcv_f2i u_f2i (
    .op_a (opnd_q),
    .rm   (rm_q),
    .res  (f2i_res),
    .inv  (f2i_inv),
    .inx  (f2i_inx)
  );

  fcv_i2f u_i2f (
    .op_a (opnd_q),
    .rm   (rm_q),
    .res  (i2f_res),
    .inx  (i2f_inx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q      <= 1'b0;
      opnd_q      <= '0;
      rm_q        <= RM_NEAREST;
      tof_q       <= 1'b0;
      out_valid   <= 1'b0;
      out_result  <= '0;
      out_invalid <= 1'b0;
      out_inexact <= 1'b0;
    end else begin
      busy_q    <= accept;
      out_valid <= busy_q;
      if (accept) begin
        opnd_q <= in_operand;
        rm_q   <= dec.rm;
        tof_q  <= dec.to_float;
      end
      if (busy_q) begin
        out_result  <= tof_q ? i2f_res : f2i_res;
        out_invalid <= tof_q ? 1'b0    : f2i_inv;
        out_inexact <= tof_q ? i2f_inx : f2i_inx;
      end
    end
  end
endmodule

// File: rtl/fcv_unit_chk.sv
module fcv_unit_chk
  import fcv_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [OP_W-1:0]   in_opcode,
  input logic [OP_W-1:0]   in_subop,
  input logic              out_valid,
  input logic [WORD_W-1:0] out_result,
  input logic              out_invalid,
  input logic              out_inexact
);
  logic known;
  logic take;
  logic drop;

  assign known = (in_subop == SUB_FIX &&
                  (in_opcode == OPC_NEAR || in_opcode == OPC_TRUNC ||
                   in_opcode == OPC_CEIL || in_opcode == OPC_FLOOR)) ||
                 (in_opcode == OPC_DYN  && in_subop == SUB_DYN) ||
                 (in_opcode == OPC_ITOF && in_subop == SUB_ITOF);
  assign take = in_valid && in_ready && known;
  assign drop = in_valid && in_ready && !known;

  AST_GAP_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (!out_valid && !in_ready)); // R2
  AST_DONE_ON_TIME: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> ##2 out_valid); // R2
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid); // R2
  AST_SAT_ON_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_invalid) |-> (out_result == SAT_POS || out_result == SAT_NEG)); // R7
  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(out_invalid && out_inexact)); // R7
  AST_DROP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    drop |-> ##2 !out_valid); // R10
endmodule

bind fcv_unit fcv_unit_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .in_opcode   (in_opcode),
  .in_subop    (in_subop),
  .out_valid   (out_valid),
  .out_result  (out_result),
  .out_invalid (out_invalid),
  .out_inexact (out_inexact)
);

// File: tb/fcv_unit_tb.sv
module fcv_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [3:0]  in_opcode = 4'h0;
  logic [3:0]  in_subop = 4'h0;
  logic [31:0] in_operand = '0;
  logic [1:0]  rnd_mode = 2'd0;
  logic        out_valid;
  logic [31:0] out_result;
  logic        out_invalid;
  logic        out_inexact;

  int n_chk = 0;
  int n_err = 0;

  always #5 clk = ~clk;

  fcv_unit u_dut (
    .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_ready (in_ready),
    .in_opcode (in_opcode), .in_subop (in_subop), .in_operand (in_operand),
    .rnd_mode (rnd_mode), .out_valid (out_valid), .out_result (out_result),
    .out_invalid (out_invalid), .out_inexact (out_inexact)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // -1 below half, 0 exact half, 1 above half
  function automatic int cmp_half(input longint rem, input int sh);
    if (sh >= 60) return -1;
    if (rem * 2 < (64'sd1 <<< sh)) return -1;
    if (rem * 2 == (64'sd1 <<< sh)) return 0;
    return 1;
  endfunction

  function automatic bit bump(input int rm, input bit s, input longint q,
                              input longint rem, input int c);
    if (rem == 0) return 1'b0;
    case (rm)
      0: return (c > 0) || (c == 0 && q[0]);
      1: return 1'b0;
      2: return !s;
      default: return s;
    endcase
  endfunction

  task automatic ref_f2i(input logic [31:0] a, input int rm, output logic [31:0] r,
                         output logic inv, output logic inx);
    bit s; int e; int ee; longint mant; longint q; longint rem; longint lim; int sh;
    s = a[31]; e = int'(a[30:23]); mant = longint'(a[22:0]);
    inv = 1'b0; inx = 1'b0; r = '0;
    if (e == 255) begin
      inv = 1'b1;
      r = (a[22:0] != 0 || !s) ? 32'h7FFFFFFF : 32'h80000000;
      return;
    end
    if (e != 0) mant = mant + (64'sd1 <<< 23);
    ee = (e == 0) ? 1 : e;
    lim = s ? (64'sd1 <<< 31) : ((64'sd1 <<< 31) - 1);
    if (ee >= 150) begin
      if (ee - 150 >= 40) q = lim + 1;
      else q = mant <<< (ee - 150);
      rem = 0;
    end else begin
      sh = 150 - ee;
      if (sh >= 60) begin q = 0; rem = mant; end
      else begin q = mant >>> sh; rem = mant - (q <<< sh); end
      q = q + longint'(bump(rm, s, q, rem, cmp_half(rem, sh)));
    end
    if (q > lim) begin
      inv = 1'b1;
      r = s ? 32'h80000000 : 32'h7FFFFFFF;
      return;
    end
    inx = (rem != 0);
    r = s ? 32'(-q) : 32'(q);
  endtask

  task automatic ref_i2f(input logic [31:0] a, input int rm, output logic [31:0] r,
                         output logic inx);
    bit s; longint m; longint q; longint rem; int p; int sh;
    s = a[31];
    m = s ? -longint'($signed(a)) : longint'(a);
    inx = 1'b0; r = '0;
    if (m == 0) return;
    p = 0;
    for (int i = 0; i < 32; i++) if (m[i]) p = i;
    if (p <= 23) begin
      q = m <<< (23 - p);
      rem = 0;
    end else begin
      sh = p - 23;
      q = m >>> sh;
      rem = m - (q <<< sh);
      q = q + longint'(bump(rm, s, q, rem, cmp_half(rem, sh)));
      if (q == (64'sd1 <<< 24)) begin q = 64'sd1 <<< 23; p++; end
    end
    inx = (rem != 0);
    r = {s, 8'(127 + p), q[22:0]};
  endtask

  function automatic string tag_of(input logic [3:0] op, input logic [3:0] sub);
    if (op == 4'h0 && sub == 4'h9) return "R9";
    if (op == 4'h4) return "R6";
    if (op == 4'hC) return "R3";
    if (op == 4'hD) return "R4";
    return "R5";
  endfunction

  task automatic run_op(input logic [3:0] op, input logic [3:0] sub, input int rm,
                        input logic [31:0] a);
    logic [31:0] er; logic ei; logic ex; string tg;
    tg = tag_of(op, sub);
    if (op == 4'h0) begin ref_i2f(a, rm, er, ex); ei = 1'b0; end
    else ref_f2i(a, rm, er, ei, ex);
    @(negedge clk);
    chk("R2 ready before take", 32'(in_ready), 32'd1);
    in_valid = 1'b1; in_opcode = op; in_subop = sub; in_operand = a;
    rnd_mode = 2'(rm);
    @(negedge clk);
    in_valid = 1'b0;
    rnd_mode = ~2'(rm); // R6: mode must be the sampled one
    in_operand = ~a;
    chk("R2 gap cycle", {30'd0, out_valid, in_ready}, 32'd0);
    @(negedge clk);
    chk("R2 done strobe", {30'd0, out_valid, in_ready}, 32'd3);
    chk({tg, " result"}, out_result, er);
    chk((ei || op != 4'h0) ? "R7 invalid" : "R9 invalid", 32'(out_invalid), 32'(ei));
    chk((op == 4'h0) ? "R9 inexact" : "R8 inexact", 32'(out_inexact), 32'(ex));
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired act=running exp=finished");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] fr_list [8];
    logic [3:0]  op_list [4];
    logic [31:0] held;
    fr_list[0] = 23'h000000; fr_list[1] = 23'h000001; fr_list[2] = 23'h400000;
    fr_list[3] = 23'h7FFFFF; fr_list[4] = 23'h1ABCDE; fr_list[5] = 23'h200000;
    fr_list[6] = 23'h000003; fr_list[7] = 23'h600000;
    op_list[0] = 4'hC; op_list[1] = 4'hD; op_list[2] = 4'hE; op_list[3] = 4'hF;

    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 out_valid", 32'(out_valid), 32'd0);
    chk("R1 in_ready", 32'(in_ready), 32'd1);
    chk("R1 result", out_result, 32'd0);
    chk("R1 flags", {30'd0, out_invalid, out_inexact}, 32'd0);
    rst_n = 1'b1;

    // R3 R4 R5 R6 R7 R8: float sweep, subnormal through overflow
    for (int s = 0; s < 2; s++) begin
      for (int ei = 0; ei < 65; ei++) begin
        int e;
        e = (ei == 0) ? 0 : (ei == 1) ? 1 : (ei == 63) ? 254 : (ei == 64) ? 255 : 98 + ei;
        for (int f = 0; f < 8; f++) begin
          logic [31:0] a;
          a = {1'(s), 8'(e), fr_list[f][22:0]};
          for (int k = 0; k < 4; k++) run_op(op_list[k], 4'h0, k, a);
          for (int rm = 0; rm < 4; rm++) run_op(4'h4, 4'h1, rm, a);
        end
      end
    end

    // R9: integer to float sweep
    for (int rm = 0; rm < 4; rm++) begin
      for (int v = -300; v <= 300; v++) run_op(4'h0, 4'h9, rm, 32'(v));
      for (int k = 20; k < 32; k++) begin
        for (int d = -3; d <= 3; d++) begin
          run_op(4'h0, 4'h9, rm, 32'((64'sd1 <<< k) + d));
          run_op(4'h0, 4'h9, rm, 32'(-((64'sd1 <<< k) + d)));
        end
      end
      run_op(4'h0, 4'h9, rm, 32'h7FFFFFFF);
      run_op(4'h0, 4'h9, rm, 32'h80000000);
    end

    // R10: unknown pairs are dropped silently
    held = out_result;
    for (int u = 0; u < 3; u++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_opcode = (u == 0) ? 4'h1 : (u == 1) ? 4'hC : 4'h4;
      in_subop  = (u == 0) ? 4'h0 : (u == 1) ? 4'h1 : 4'h9;
      in_operand = 32'h3F800000;
      @(negedge clk);
      in_valid = 1'b0;
      for (int w = 0; w < 3; w++) begin
        chk("R10 no strobe", {30'd0, out_valid, in_ready}, 32'd1);
        chk("R10 result held", out_result, held);
        @(negedge clk);
      end
    end

    summary();
    $finish;
  end
endmodule